// File: doc/BRIEF.md
# Flash Lock-Bit Set Sequencer

This block sits on the host side of a parallel flash command port. It runs the whole procedure for setting one lock-bit. A one-cycle start pulse, with a select that picks block or device-wide (master) protection, launches a fixed series of bus transfers. The series is a setup write, then a confirm write, then status reads that repeat until the flash reports ready. The final status byte is reduced to a result code by a fixed-priority check. Any error is cleared with a clear-status command. Every sequence ends with a write that returns the flash to array reads.

Each transfer uses a simple request/acknowledge handshake. The block raises a request and holds the direction, address and data steady until the acknowledge comes. The slave may stretch any transfer by any number of cycles. A bounded poll counter stops a flash that never becomes ready from hanging the block. While a sequence is in flight, further start pulses have no effect.

Top module: `flash_lock_seq`

## Requirements
- R1: After reset, bus_req_o, done_o and busy_o are 0.
- R2: A sequence first writes 60h to the captured address, then writes the confirm code to the same address: 01h when master_i was 0 at start (block lock), F1h when master_i was 1 (master lock).
- R3: While bus_req_o is 1 and bus_ack_i is 0, the next cycle keeps bus_req_o at 1 with bus_we_o, bus_addr_o and bus_wdata_o unchanged. A transfer completes in the cycle bus_ack_i is 1, and read data is taken from bus_rdata_i in that cycle.
- R4: After the confirm, the block reads status (bus_we_o = 0) from the same address. It repeats the read while bit 7 of the returned byte is 0 and stops at the first read with bit 7 = 1.
- R5: The ready status byte is decoded by priority into result_o: bit 3 set gives 1 (voltage range error); otherwise bit 1 set gives 2 (protect error); otherwise bits 4 and 5 both set give 3 (command sequence error); otherwise bit 4 set gives 4 (lock-bit set error); otherwise 0 (success). Bit 5 alone therefore gives 0.
- R6: When the decoded result is 1, 2, 3 or 4, a write of 50h to the same address follows the last status read. When the result is 0, no such write occurs.
- R7: Every sequence's last transfer is a write of FFh to the same address. In the cycle after that write completes, done_o is 1 for exactly one cycle and result_o holds the result. One cycle later busy_o is 0.
- R8: If POLL_LIMIT consecutive status reads all return bit 7 = 0, polling stops, no 50h write is issued, FFh is written and the result is 5 (timeout). A ready byte on read POLL_LIMIT is still decoded normally.
- R9: A start_i pulse while busy_o is 1 changes neither the address, the lock kind nor the transfer series of the running sequence, and it starts no sequence afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse, taken only while idle |
| master_i | input | 1 | 1 selects the master lock-bit, 0 a block lock-bit |
| addr_i | input | AW | Block or device address for the sequence |
| bus_req_o | output | 1 | Transfer request |
| bus_we_o | output | 1 | 1 = write, 0 = status read |
| bus_addr_o | output | AW | Transfer address |
| bus_wdata_o | output | 8 | Write command byte |
| bus_ack_i | input | 1 | Transfer acknowledge |
| bus_rdata_i | input | 8 | Status byte returned on a read |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |
| result_o | output | 3 | Outcome code (see R5, R8) |

## Verification
A corrupted sequencer state appears on the bus at the next acknowledged transfer: a wrong command byte, a wrong direction, a missing or extra 50h, or an early FFh. The bench model compares each transfer as it completes, so the mismatch is caught in the same cycle. A wrong poll count or a wrong decode priority shows up as an extra or missing status read, or as a wrong result_o at the done pulse. A fault in the handshake hold shows up on the first clock in which the slave stretches a transfer.

// File: rtl/flash_lock_pkg.sv
package flash_lock_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_CONFIRM,
    ST_POLL,
    ST_CLEAR,
    ST_ARRAY,
    ST_DONE
  } seq_state_e;

  typedef enum logic [2:0] {
    RES_OK      = 3'd0,
    RES_VPP     = 3'd1,
    RES_PROT    = 3'd2,
    RES_CMDSEQ  = 3'd3,
    RES_LOCK    = 3'd4,
    RES_TIMEOUT = 3'd5
  } lock_res_e;

  localparam logic [7:0] CMD_LOCK_SETUP = 8'h60;
  localparam logic [7:0] CMD_CONF_BLOCK = 8'h01;
  localparam logic [7:0] CMD_CONF_MASTER = 8'hF1;
  localparam logic [7:0] CMD_CLR_STATUS = 8'h50;
  localparam logic [7:0] CMD_READ_ARRAY = 8'hFF;

  localparam int unsigned SB_READY = 7;
  localparam int unsigned SB_SEQ   = 5;
  localparam int unsigned SB_LOCK  = 4;
  localparam int unsigned SB_VOLT  = 3;
  localparam int unsigned SB_PROT  = 1;

endpackage

// File: rtl/fls_status_decode.sv
module fls_status_decode
  import flash_lock_pkg::*;
(
  input  logic [7:0] status_i,
  output logic       ready_o,
  output lock_res_e  res_o
);

  logic unused_bits;
  assign unused_bits = ^{status_i[6], status_i[2], status_i[0]};

  assign ready_o = status_i[SB_READY];

  // fixed priority: voltage, protect, sequence, lock
  always_comb begin
    if (status_i[SB_VOLT])                          res_o = RES_VPP;
    else if (status_i[SB_PROT])                     res_o = RES_PROT;
    else if (status_i[SB_LOCK] && status_i[SB_SEQ]) res_o = RES_CMDSEQ;
    else if (status_i[SB_LOCK])                     res_o = RES_LOCK;
    else                                            res_o = RES_OK;
  end

endmodule

// File: rtl/fls_poll_timer.sv
module fls_poll_timer #(
  parameter int unsigned POLL_LIMIT = 64
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic inc_i,
  output logic last_o
);

  localparam int unsigned CW = (POLL_LIMIT < 2) ? 1 : $clog2(POLL_LIMIT + 1);
  localparam logic [CW-1:0] LAST_VAL = CW'(POLL_LIMIT - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else if (inc_i) cnt_q <= cnt_q + 1'b1;
  end

  assign last_o = (cnt_q == LAST_VAL);

  p_cnt_bound_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST_VAL);

  p_inc_not_last_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && !clr_i) |=> (cnt_q != '0));

endmodule

// File: rtl/flash_lock_seq.sv
module flash_lock_seq
  import flash_lock_pkg::*;
#(
  parameter int unsigned AW         = 16,
  parameter int unsigned POLL_LIMIT = 64
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          master_i,
  input  logic [AW-1:0] addr_i,
  output logic          bus_req_o,
  output logic          bus_we_o,
  output logic [AW-1:0] bus_addr_o,
  output logic [7:0]    bus_wdata_o,
  input  logic          bus_ack_i,
  input  logic [7:0]    bus_rdata_i,
  output logic          busy_o,
  output logic          done_o,
  output logic [2:0]    result_o
);

  seq_state_e    state_q, state_d;
  lock_res_e     res_q, res_d;
  logic          master_q;
  logic [AW-1:0] addr_q;

  logic      st_ready;
  lock_res_e st_res;
  logic      poll_last;
  logic      poll_inc;
  logic      capture;

  fls_status_decode u_decode (
    .status_i (bus_rdata_i),
    .ready_o  (st_ready),
    .res_o    (st_res)
  );

  fls_poll_timer #(.POLL_LIMIT(POLL_LIMIT)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (state_q != ST_POLL),
    .inc_i  (poll_inc),
    .last_o (poll_last)
  );

  assign capture  = (state_q == ST_IDLE) && start_i;
  assign poll_inc = (state_q == ST_POLL) && bus_ack_i && !st_ready && !poll_last;

  always_comb begin
    state_d = state_q;
    res_d   = res_q;
    unique case (state_q)
      ST_IDLE:    if (start_i) state_d = ST_SETUP;
      ST_SETUP:   if (bus_ack_i) state_d = ST_CONFIRM;
      ST_CONFIRM: if (bus_ack_i) state_d = ST_POLL;
      ST_POLL: begin
        if (bus_ack_i) begin
          if (st_ready) begin
            res_d   = st_res;
            state_d = (st_res == RES_OK) ? ST_ARRAY : ST_CLEAR;
          end else if (poll_last) begin
            res_d   = RES_TIMEOUT;
            state_d = ST_ARRAY;
          end
        end
      end
      ST_CLEAR:   if (bus_ack_i) state_d = ST_ARRAY;
      ST_ARRAY:   if (bus_ack_i) state_d = ST_DONE;
      ST_DONE:    state_d = ST_IDLE;
      default:    state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      res_q    <= RES_OK;
      master_q <= 1'b0;
      addr_q   <= '0;
    end else begin
      state_q <= state_d;
      res_q   <= res_d;
      if (capture) begin
        master_q <= master_i;
        addr_q   <= addr_i;
      end
    end
  end

  always_comb begin
    bus_req_o   = 1'b1;
    bus_we_o    = 1'b1;
    bus_wdata_o = 8'h00;
    unique case (state_q)
      ST_SETUP:   bus_wdata_o = CMD_LOCK_SETUP;
      ST_CONFIRM: bus_wdata_o = master_q ? CMD_CONF_MASTER : CMD_CONF_BLOCK;
      ST_POLL:    bus_we_o    = 1'b0;
      ST_CLEAR:   bus_wdata_o = CMD_CLR_STATUS;
      ST_ARRAY:   bus_wdata_o = CMD_READ_ARRAY;
      default: begin
        bus_req_o = 1'b0;
        bus_we_o  = 1'b0;
      end
    endcase
  end

  assign bus_addr_o = addr_q;
  assign busy_o     = (state_q != ST_IDLE);
  assign done_o     = (state_q == ST_DONE);
  assign result_o   = res_q;

  p_req_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_o && !bus_ack_i) |=> (bus_req_o && $stable(bus_we_o)
      && $stable(bus_addr_o) && $stable(bus_wdata_o)));

  p_poll_follows_confirm_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_CONFIRM && bus_ack_i) |=> (bus_req_o && !bus_we_o));

  p_clear_only_on_err_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_CLEAR) |-> (res_q != RES_OK && res_q != RES_TIMEOUT));

  p_done_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> (!done_o && !busy_o));

  p_done_quiet_bus_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !bus_req_o);

  p_start_ignored_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> ($stable(addr_q) && $stable(master_q)));

endmodule

// File: tb/flash_lock_seq_tb.sv
module flash_lock_seq_tb;

  localparam int AW    = 16;
  localparam int LIMIT = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic          master = 1'b0;
  logic [AW-1:0] addr = '0;
  logic          req, we;
  logic [AW-1:0] baddr;
  logic [7:0]    wdata;
  logic          ack = 1'b0;
  logic [7:0]    rdata = 8'h00;
  logic          busy, done;
  logic [2:0]    result;

  always #10 clk = ~clk;

  flash_lock_seq #(.AW(AW), .POLL_LIMIT(LIMIT)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .master_i(master),
    .addr_i(addr), .bus_req_o(req), .bus_we_o(we), .bus_addr_o(baddr),
    .bus_wdata_o(wdata), .bus_ack_i(ack), .bus_rdata_i(rdata),
    .busy_o(busy), .done_o(done), .result_o(result)
  );

  int tests = 0;
  int fails = 0;
  int cycles = 0;

  // expected transfer queue
  logic          q_we[$];
  logic [AW-1:0] q_addr[$];
  logic [7:0]    q_dat[$];
  string         q_tag[$];

  int       busy_left = 0;
  logic [7:0] fin_status = 8'h00;
  int       dly = 0;
  int       wcnt = 0;
  logic     p_req = 1'b0, p_we = 1'b0;
  logic [AW-1:0] p_addr = '0;
  logic [7:0]    p_wd = '0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int ref_res(input logic [7:0] s);
    if (s[3]) return 1;
    if (s[1]) return 2;
    if (s[4] && s[5]) return 3;
    if (s[4]) return 4;
    return 0;
  endfunction

  task automatic push(input logic w, input logic [AW-1:0] a, input logic [7:0] d,
                      input string t);
    q_we.push_back(w); q_addr.push_back(a); q_dat.push_back(d); q_tag.push_back(t);
  endtask

  // flash slave model with per-clock protocol comparison
  always @(negedge clk) begin
    if (rst_n) begin
      if (p_req && !ack)
        chk(req && we == p_we && baddr == p_addr && wdata == p_wd, "R3 hold",
            {req, we, baddr, wdata}, {1'b1, p_we, p_addr, p_wd});
      p_req = req; p_we = we; p_addr = baddr; p_wd = wdata;
      if (ack) begin
        ack = 1'b0;
        wcnt = 0;
      end else if (req) begin
        if (wcnt >= dly) begin
          ack = 1'b1;
          if (!we) begin
            if (busy_left > 0) begin rdata = 8'h00; busy_left--; end
            else rdata = fin_status | 8'h80;
          end
          if (q_we.size() == 0) begin
            chk(1'b0, "R7 unexpected transfer", {we, wdata}, 0);
          end else begin
            chk(we == q_we[0] && baddr == q_addr[0] && (!we || wdata == q_dat[0]),
                q_tag[0], {we, baddr, wdata}, {q_we[0], q_addr[0], q_dat[0]});
            void'(q_we.pop_front()); void'(q_addr.pop_front());
            void'(q_dat.pop_front()); void'(q_tag.pop_front());
          end
        end else wcnt++;
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++; tests++;
      $display("FAIL watchdog actual=%0d expected=<150000", cycles);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic run_seq(input logic m, input logic [AW-1:0] a, input int nbusy,
                         input logic [7:0] st, input int d, input bit poke,
                         input string tag);
    int nreads, er;
    bit seen;
    nreads = (nbusy >= LIMIT) ? LIMIT : nbusy + 1;
    er = (nbusy >= LIMIT) ? 5 : ref_res(st);
    push(1'b1, a, 8'h60, "R2 setup");
    push(1'b1, a, m ? 8'hF1 : 8'h01, "R2 confirm");
    for (int i = 0; i < nreads; i++) push(1'b0, a, 8'h00, "R4 poll");
    if (er >= 1 && er <= 4) push(1'b1, a, 8'h50, "R6 clear");
    push(1'b1, a, 8'hFF, "R7 read array");
    busy_left = nbusy; fin_status = st; dly = d;
    @(negedge clk);
    start = 1'b1; master = m; addr = a;
    @(negedge clk);
    start = 1'b0;
    seen = 1'b0;
    for (int c = 0; c < 3000 && !seen; c++) begin
      @(negedge clk);
      if (poke && c == 3) begin start = 1'b1; master = ~m; addr = ~a; end
      if (poke && c == 4) start = 1'b0;
      if (done) seen = 1'b1;
    end
    chk(seen, {tag, " R7 done"}, seen, 1);
    chk(result == 3'(er), {tag, (er == 5) ? " R8 result" : " R5 result"}, result, er);
    chk(q_we.size() == 0, {tag, " R6/R7 missing transfers"}, q_we.size(), 0);
    @(negedge clk);
    chk(!done && !busy, {tag, " R7 pulse"}, {done, busy}, 0);
    for (int c = 0; c < 6; c++) begin
      @(negedge clk);
      if (req) chk(1'b0, {tag, " R9 idle bus"}, req, 0);
    end
    q_we.delete(); q_addr.delete(); q_dat.delete(); q_tag.delete();
  endtask

  initial begin
    #5;
    chk(!req && !done && !busy, "R1 reset", {req, done, busy}, 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!req && !done && !busy, "R1 after release", {req, done, busy}, 0);
    run_seq(1'b0, 16'h1234, 2, 8'h00, 0, 1'b0, "block ok");
    run_seq(1'b1, 16'h0000, 0, 8'h00, 2, 1'b0, "master ok");
    run_seq(1'b0, 16'h0A0A, 3, 8'h08, 1, 1'b0, "volt");
    run_seq(1'b0, 16'h0B0B, 1, 8'h3A, 0, 1'b0, "volt prio");
    run_seq(1'b1, 16'hFFFF, 1, 8'h02, 1, 1'b0, "prot");
    run_seq(1'b1, 16'h0101, 0, 8'h32, 0, 1'b0, "prot prio");
    run_seq(1'b0, 16'h2222, 2, 8'h30, 3, 1'b0, "seq");
    run_seq(1'b0, 16'h3333, 0, 8'h10, 0, 1'b0, "lock");
    run_seq(1'b1, 16'h4444, 1, 8'h20, 1, 1'b0, "bit5 alone");
    run_seq(1'b0, 16'h5555, LIMIT - 1, 8'h00, 0, 1'b0, "R8 last read ready");
    run_seq(1'b1, 16'h6666, 100, 8'h10, 1, 1'b0, "R8 timeout");
    run_seq(1'b0, 16'h7777, 3, 8'h00, 2, 1'b1, "R9 start ignored");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule